// File: doc/BRIEF.md
# Translation Lookaside Buffer with Selective Flush

This block is a small, fully associative cache of page translations for a 32-bit virtual address space with 4 KiB pages. A lookup presents a virtual address. The upper 20 bits, the virtual page number, are compared against every cached entry at once. On a hit, the block returns the stored frame number and status flags in the same cycle. The physical address is that frame number placed above the untranslated 12-bit page offset. A write to a read-only page, or a user-mode access to a supervisor page, is reported as a protection fault instead of an address.

When no entry matches, a miss is raised. An external page-table walker then fetches the entry and writes it back through the refill port. A refill whose page number is already cached replaces that slot. Otherwise the refill takes the lowest free slot, or evicts a round-robin victim when every slot is full. When the running process changes, a flush invalidates every entry except those marked global.

Top module: `tlb_cache`

## Requirements
- R1: With `lk_valid` high, a valid entry whose present flag is set and whose page number equals `lk_vaddr[31:12]` gives `lk_hit`=1 in the same cycle, and `lk_flags` carries its flags. The flag bit positions are: bit0 present, bit1 writable, bit2 user-accessible, bit3 referenced, bit4 dirty, bit5 global.
- R2: On a hit with no fault, `lk_paddr` = {frame number, `lk_vaddr[11:0]`}. When there is no hit, or there is a fault, `lk_paddr` is 0.
- R3: `lk_miss`=1 exactly when `lk_valid` is high and there is no hit. With `lk_valid` low, `lk_hit`, `lk_miss` and `lk_fault` are all 0.
- R4: An entry stored with the present flag clear never produces a hit. A lookup of its page number reports a miss.
- R5: A cycle with `flush` high invalidates every entry whose global flag is clear and keeps global entries valid. The effect is visible from the next cycle.
- R6: A refill presented in the same cycle as a flush is dropped.
- R7: On a hit, `lk_fault`=1 when `lk_write`=1 and the writable flag is clear, or when `lk_user`=1 and the user flag is clear. `lk_fault` is never 1 without a hit.
- R8: A refill is written to one slot, chosen in this order:
  - the slot that already holds the same page number, if any;
  - otherwise the lowest-numbered invalid slot;
  - otherwise the slot named by a round-robin pointer. The pointer starts at 0 and advances by one, wrapping, only when it is used for an eviction.
- R9: After reset, no entry is valid, every lookup misses, and the round-robin pointer is 0.
- R10: A lookup in the same cycle as a refill sees the contents before that refill. The new entry becomes visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Lookup is a write access |
| lk_user | input | 1 | Lookup is made in user mode |
| lk_hit | output | 1 | A present entry matched |
| lk_miss | output | 1 | No present entry matched |
| lk_fault | output | 1 | Protection fault on the hit |
| lk_paddr | output | 32 | Translated physical address |
| lk_flags | output | 6 | Flags of the matched entry |
| rf_valid | input | 1 | Refill write strobe |
| rf_vpn | input | 20 | Page number to install |
| rf_pfn | input | 20 | Frame number to install |
| rf_flags | input | 6 | Flags to install |
| flush | input | 1 | Invalidate all non-global entries |

## Verification
The bench uses the default configuration of 8 entries, so a few refills fill the whole buffer and reach every eviction case. Each page is looked up with all four combinations of write and user mode and with several offsets, so every fault case and the offset pass-through are covered. The expected results come from a small arithmetic model of slots, flags and the round-robin pointer. Flushes are applied with a mix of global and non-global entries, and refills are also driven in the same cycle as a flush or a lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic glob;
    logic dirty;
    logic refd;
    logic user;
    logic wr;
    logic present;
  } pte_flags_t;
  localparam int FLAG_W = $bits(pte_flags_t);
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PFN_W-1:0]   wr_pfn,
  input  pte_flags_t         wr_flags,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic [ENTRIES-1:0] lk_match,
  output logic [PFN_W-1:0]   lk_pfn,
  output pte_flags_t         lk_fl,
  output logic [ENTRIES-1:0] rf_match,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  pte_flags_t         fl_q  [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] glob_vec;

  // payload storage carries no reset; validity lives in valid_q
  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx] <= wr_vpn;
      pfn_q[wr_idx] <= wr_pfn;
      fl_q[wr_idx]  <= wr_flags;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        valid_q <= '0;
    else if (flush) valid_q <= valid_q & glob_vec;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign glob_vec[i] = fl_q[i].glob;
    assign lk_match[i] = valid_q[i] && fl_q[i].present && (vpn_q[i] == lk_vpn);
    assign rf_match[i] = valid_q[i] && (vpn_q[i] == wr_vpn);
  end

  always_comb begin
    lk_pfn = '0;
    lk_fl  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_pfn = lk_pfn | pfn_q[i];
        lk_fl  = lk_fl  | fl_q[i];
      end
    end
  end

  assign valid_vec = valid_q;

  // R1: refill deduplication keeps page numbers unique, so at most one match
  p_single_match_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));
  // R5: flush keeps exactly the global entries
  p_flush_keeps_glob_r5: assert property (@(posedge clk) disable iff (rst)
    flush |=> valid_q == $past(valid_q & glob_vec));
  // R8: a refill always leaves its slot valid
  p_fill_sets_valid_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush) |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] same_vec,
  output logic [IDX_W-1:0]   slot
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] same_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_same;
  logic             any_free;
  logic             evict;

  always_comb begin
    same_idx = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (same_vec[i])   same_idx = IDX_W'(i);
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_same = |same_vec;
  assign any_free = ~&valid_vec;
  assign evict    = req && !any_same && !any_free;
  assign slot     = any_same ? same_idx : (any_free ? free_idx : rr_q);

  always_ff @(posedge clk) begin
    if (rst) rr_q <= '0;
    else if (evict) rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  // R8: pointer steps by one, wrapping, on each eviction
  p_rr_step_r8: assert property (@(posedge clk) disable iff (rst)
    evict |=> rr_q == (($past(rr_q) == IDX_W'(ENTRIES - 1)) ? '0 : $past(rr_q) + 1'b1));
  // R8: pointer holds when no eviction happens
  p_rr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !evict |=> $stable(rr_q));
  // R8: a non-matching refill with room goes into a free slot
  p_free_pick_r8: assert property (@(posedge clk) disable iff (rst)
    (req && !any_same && any_free) |-> !valid_vec[slot]);
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlb_pkg::*;
(
  input  logic       hit,
  input  pte_flags_t fl,
  input  logic       is_write,
  input  logic       is_user,
  output logic       fault
);
  logic deny_write;
  logic deny_user;

  assign deny_write = is_write && !fl.wr;
  assign deny_user  = is_user && !fl.user;
  assign fault      = hit && (deny_write || deny_user);

  // R7: no fault is raised without a hit
  always_comb begin
    if (!hit) p_fault_needs_hit_r7: assert (!fault);
  end
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 20,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = PFN_W + OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              lk_write,
  input  logic              lk_user,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_fault,
  output logic [PA_W-1:0]   lk_paddr,
  output logic [FLAG_W-1:0] lk_flags,
  input  logic              rf_valid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [PFN_W-1:0]  rf_pfn,
  input  logic [FLAG_W-1:0] rf_flags,
  input  logic              flush
);
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] same_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic [PFN_W-1:0]   hit_pfn;
  pte_flags_t         hit_fl;
  logic [IDX_W-1:0]   slot;
  logic               fill;
  logic               any_match;
  logic               fault_raw;

  // flush wins over a simultaneous refill
  assign fill = rf_valid && !flush;

  tlb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_arr (
    .clk(clk), .rst(rst), .flush(flush), .wr_en(fill), .wr_idx(slot),
    .wr_vpn(rf_vpn), .wr_pfn(rf_pfn), .wr_flags(pte_flags_t'(rf_flags)),
    .lk_vpn(lk_vaddr[VA_W-1:OFF_W]), .lk_match(match_vec), .lk_pfn(hit_pfn),
    .lk_fl(hit_fl), .rf_match(same_vec), .valid_vec(valid_vec)
  );

  tlb_victim_sel #(.ENTRIES(ENTRIES)) u_vic (
    .clk(clk), .rst(rst), .req(fill), .valid_vec(valid_vec),
    .same_vec(same_vec), .slot(slot)
  );

  assign any_match = lk_valid && (|match_vec);

  tlb_perm_check u_perm (
    .hit(any_match), .fl(hit_fl), .is_write(lk_write), .is_user(lk_user),
    .fault(fault_raw)
  );

  assign lk_hit   = any_match;
  assign lk_miss  = lk_valid && !any_match;
  assign lk_fault = fault_raw;
  assign lk_paddr = (any_match && !fault_raw) ? {hit_pfn, lk_vaddr[OFF_W-1:0]} : '0;
  assign lk_flags = any_match ? FLAG_W'(hit_fl) : '0;

  // R3: hit and miss never coincide
  p_hit_miss_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(lk_hit && lk_miss));
  // R2: a faulting access yields no address
  p_fault_no_addr_r2: assert property (@(posedge clk) disable iff (rst)
    lk_fault |-> lk_paddr == '0);
  // R3: an idle lookup port reports nothing
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> !(lk_hit || lk_miss || lk_fault));
endmodule

// File: tb/sim_tlb_cache.sv
module sim_tlb_cache;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0, lk_write = 1'b0, lk_user = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic lk_hit, lk_miss, lk_fault;
  logic [31:0] lk_paddr;
  logic [5:0] lk_flags;
  logic rf_valid = 1'b0, flush = 1'b0;
  logic [19:0] rf_vpn = '0, rf_pfn = '0;
  logic [5:0] rf_flags = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model
  bit        m_v   [8];
  bit [19:0] m_vpn [8];
  bit [19:0] m_pfn [8];
  bit [5:0]  m_fl  [8];
  int        m_rr = 0;

  always #2 clk = ~clk;

  tlb_cache u0 (.*);

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic look(bit [31:0] va, bit wr, bit us, string req);
    int  idx = -1;
    bit  eh, em, ef;
    bit [31:0] ep;
    bit [5:0]  efl;
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va; lk_write = wr; lk_user = us;
    #1;
    for (int i = 0; i < 8; i++)
      if (m_v[i] && m_fl[i][0] && m_vpn[i] == va[31:12]) idx = i;
    eh  = (idx >= 0);
    em  = !eh;
    ef  = eh && ((wr && !m_fl[idx][1]) || (us && !m_fl[idx][2]));
    ep  = (eh && !ef) ? {m_pfn[idx], va[11:0]} : 32'h0;
    efl = eh ? m_fl[idx] : 6'h0;
    check({lk_hit, lk_miss, lk_fault, lk_paddr, lk_flags} == {eh, em, ef, ep, efl}, req,
          "hit/miss/fault/paddr/flags", {23'h0, lk_hit, lk_miss, lk_fault, lk_paddr, lk_flags},
          {23'h0, eh, em, ef, ep, efl});
  endtask

  function automatic void model_fill(bit [19:0] vpn, bit [19:0] pfn, bit [5:0] fl);
    int s = -1;
    for (int i = 7; i >= 0; i--) if (m_v[i] && m_vpn[i] == vpn) s = i;
    if (s < 0) for (int i = 7; i >= 0; i--) if (!m_v[i]) s = i;
    if (s < 0) begin s = m_rr; m_rr = (m_rr + 1) % 8; end
    m_v[s] = 1; m_vpn[s] = vpn; m_pfn[s] = pfn; m_fl[s] = fl;
  endfunction

  function automatic void model_flush();
    for (int i = 0; i < 8; i++) if (!m_fl[i][5]) m_v[i] = 0;
  endfunction

  task automatic refill(bit [19:0] vpn, bit [19:0] pfn, bit [5:0] fl, bit with_flush);
    @(negedge clk);
    rf_valid = 1; rf_vpn = vpn; rf_pfn = pfn; rf_flags = fl; flush = with_flush;
    @(posedge clk);
    if (with_flush) model_flush(); else model_fill(vpn, pfn, fl);
    @(negedge clk);
    rf_valid = 0; flush = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(posedge clk); model_flush();
    @(negedge clk); flush = 0;
  endtask

  task automatic sweep_all(string req);
    for (int i = 0; i < 8; i++)
      for (int c = 0; c < 4; c++)
        look({m_vpn[i], 12'(i * 353 + c * 1021)}, c[0], c[1], req);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R9: empty after reset
    for (int v = 0; v < 4; v++) look({20'(v * 4099), 12'h123}, 0, 0, "R9");
    // R3: idle port quiet
    @(negedge clk); lk_valid = 0; #1;
    check({lk_hit, lk_miss, lk_fault} == 3'b000, "R3", "idle outputs", lk_hit, 0);
    // R1 R2 R7 R8: fill all slots with varied flags (present set)
    for (int i = 0; i < 8; i++)
      refill(20'h100 + 20'(i), 20'(i * 3 + 5), 6'((i * 11) | 1), 0);
    sweep_all("R1 R2 R7");
    look({20'h100, 12'hfff}, 0, 0, "R2");
    look({20'h100, 12'h000}, 0, 0, "R2");
    look(32'h0, 0, 0, "R3");
    // R8: evictions walk the round-robin pointer
    refill(20'h200, 20'hABCDE, 6'h07, 0);
    refill(20'h201, 20'h12345, 6'h03, 0);
    look({20'h100, 12'h0}, 0, 0, "R8");
    look({20'h101, 12'h0}, 0, 0, "R8");
    sweep_all("R8");
    // R8: same page overwrites in place, pointer unchanged
    refill(20'h105, 20'h55555, 6'h27, 0);
    sweep_all("R8");
    refill(20'h202, 20'h0F0F0, 6'h07, 0);
    sweep_all("R8");
    // R4: present clear never hits
    refill(20'h203, 20'h11111, 6'h26, 0);
    look({20'h203, 12'h010}, 0, 0, "R4");
    // R5: flush keeps globals only
    do_flush();
    sweep_all("R5");
    look({20'h105, 12'h444}, 0, 0, "R5");
    // R8: refills after flush go to lowest free slots
    refill(20'h300, 20'h00777, 6'h07, 0);
    refill(20'h301, 20'h00778, 6'h03, 0);
    sweep_all("R8");
    // R6: refill dropped with flush
    refill(20'h3FF, 20'h99999, 6'h27, 1);
    look({20'h3FF, 12'h0}, 0, 0, "R6");
    // R10: same-cycle lookup sees old contents
    @(negedge clk);
    rf_valid = 1; rf_vpn = 20'h777; rf_pfn = 20'h4242; rf_flags = 6'h07;
    lk_valid = 1; lk_vaddr = {20'h777, 12'h0}; lk_write = 0; lk_user = 0; #1;
    check(lk_miss && !lk_hit, "R10", "lookup during refill", {lk_hit, lk_miss}, 2'b01);
    @(posedge clk); model_fill(20'h777, 20'h4242, 6'h07);
    @(negedge clk); rf_valid = 0;
    look({20'h777, 12'hABC}, 1, 1, "R10");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule